// File: doc/BRIEF.md
# Bounds-Checked Jump Table Branch Unit

This unit resolves a multi-way branch whose jump table sits in the instruction stream directly after the branch. The table starts 4 bytes past the branch's own address, so the code stays position independent. Given a signed selector, an unsigned upper bound and an entry-width code, the unit picks one table slot. A selector outside the legal span is redirected to a built-in fallback slot at position bound+1. The unit forms the slot's byte address and reads the entry. It then produces the next fetch address.

The entry is taken directly from an 8-word instruction-buffer window when it lies wholly inside that window, which gives a one-cycle answer. Otherwise the unit issues a read on an instruction-cache port and waits a variable number of cycles for the reply. In the default mode the entry is a signed displacement counted in 4-byte words and added to the branch address. An alternate mode splices the entry into the low-order bits of the branch address instead.

Top module: `jtbl_branch_unit`

## Requirements
- R1: After reset, and whenever reset is applied mid-operation, `ready_o` is 1 and `done_o`, `illegal_o` and `ic_req_o` are 0.
- R2: A selector that is non-negative and no greater than `bound_i` addresses the entry at `br_addr_i + 4 + sel * W`, where W is the entry width in bytes.
- R3: A selector that is negative (two's complement, MSB set) or greater than `bound_i` addresses the fallback slot `bound_i + 1`. `bound_i` may be 65535, so the fallback can be slot 65536.
- R4: `esize_i` sets the entry width: 0 gives 1 byte, 1 gives 2 bytes, 2 gives 4 bytes and 3 gives 8 bytes. The slot number is scaled by that width.
- R5: In add mode (`splice_i`=0), `target_o` equals `br_addr_i` plus the sign-extended entry shifted left by 2. Entries are little-endian, with the lowest address in the least significant byte.
- R6: When the whole entry lies inside the window of 32 bytes starting at `ibuf_base_i`, `done_o` rises in the cycle after the accepted `start_i`. No cache read is issued. Byte b of the window is `ibuf_data_i[8b+7:8b]`.
- R7: An entry that lies outside the window, or that crosses its upper edge, raises `ic_req_o` in the cycle after start, with `ic_addr_o` set to the entry address. Both hold until `ic_valid_i` is seen. `done_o` follows in the next cycle. `ic_data_i[8k+7:8k]` is the byte at `ic_addr_o + k`.
- R8: In splice mode (`splice_i`=1), `target_o` is `br_addr_i` with its low 8W bits replaced by the entry.
- R9: Splice mode with `esize_i`=0 is illegal. It produces `done_o` and `illegal_o` together in the next cycle, with `target_o` = `br_addr_i` and no cache read.
- R10: A `start_i` while a cache read is pending is ignored. The pending read address and the eventual target are unchanged, and no second completion follows.
- R11: `done_o` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe, accepted when `ready_o` is 1 |
| sel_i | input | 32 | Signed table selector |
| bound_i | input | 16 | Highest legal selector |
| esize_i | input | 2 | Entry width code |
| splice_i | input | 1 | 1 = replace low address bits, 0 = add word displacement |
| br_addr_i | input | 64 | Address of the branch |
| ibuf_base_i | input | 64 | Address of byte 0 of the buffer window |
| ibuf_data_i | input | 256 | Eight 32-bit buffer words |
| ic_req_o | output | 1 | Cache read request, held until reply |
| ic_addr_o | output | 64 | Cache read byte address |
| ic_valid_i | input | 1 | Cache reply strobe |
| ic_data_i | input | 64 | Cache reply bytes |
| ready_o | output | 1 | Unit idle, may accept a request |
| done_o | output | 1 | Target valid pulse |
| illegal_o | output | 1 | Illegal request flag, with `done_o` |
| target_o | output | 64 | Next fetch address |

## Verification
The situation hardest to reach from the ports is an 8-byte entry that begins inside the buffer window but ends past it. It can occur only when the table base and the window base are offset so that a slot lands on the window's last word. The stimulus places the branch at the window base with a negative selector and a bound of 2, which puts the fallback slot at window offset 28. A second hard case is a new strobe arriving in the middle of a cache wait. A directed test injects a conflicting request while the reply is held back, then checks that the original address and target survive.

// File: rtl/jtbl_pkg.sv
package jtbl_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_MISS = 1'b1
    } fsm_e;

    localparam int TBL_START = 4;     // table begins one instruction past the branch
    localparam int ENTRY_MAX_W = 64;  // widest entry in bits

    localparam logic [1:0] SZ_1B = 2'd0;
    localparam logic [1:0] SZ_2B = 2'd1;
    localparam logic [1:0] SZ_4B = 2'd2;
    localparam logic [1:0] SZ_8B = 2'd3;

    function automatic logic [3:0] entry_bytes(input logic [1:0] code);
        return 4'd1 << code;
    endfunction
endpackage

// File: rtl/jtbl_slot_calc.sv
module jtbl_slot_calc
    import jtbl_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int IDX_W  = 32,
    parameter int MAX_W  = 16
) (
    input  logic [IDX_W-1:0]  sel_i,
    input  logic [MAX_W-1:0]  bound_i,
    input  logic [1:0]        esize_i,
    input  logic [ADDR_W-1:0] br_addr_i,
    output logic [ADDR_W-1:0] entry_addr_o
);
    localparam int SLOT_W = MAX_W + 1;

    logic              negative;
    logic              in_span;
    logic [SLOT_W-1:0] slot;
    logic [ADDR_W-1:0] byte_ofs;

    always_comb begin
        negative = sel_i[IDX_W-1];
        in_span  = !negative && (sel_i[IDX_W-2:0] <= (IDX_W-1)'(bound_i));
        slot     = in_span ? {1'b0, sel_i[MAX_W-1:0]} : ({1'b0, bound_i} + SLOT_W'(1));
        byte_ofs = ADDR_W'(slot) << esize_i;
        entry_addr_o = br_addr_i + ADDR_W'(TBL_START) + byte_ofs;
    end
endmodule

// File: rtl/jtbl_ibuf_pick.sv
module jtbl_ibuf_pick
    import jtbl_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int BUF_WORDS = 8
) (
    input  logic [ADDR_W-1:0]       base_i,
    input  logic [BUF_WORDS*32-1:0] data_i,
    input  logic [ADDR_W-1:0]       entry_addr_i,
    input  logic [1:0]              esize_i,
    output logic                    hit_o,
    output logic [ENTRY_MAX_W-1:0]  raw_o
);
    localparam int WIN_BYTES = BUF_WORDS * 4;
    localparam int WIN_BITS  = WIN_BYTES * 8;
    localparam int OFS_W     = $clog2(WIN_BYTES);
    localparam int PAD_W     = WIN_BITS + ENTRY_MAX_W;

    logic [ADDR_W-1:0] diff;
    logic [OFS_W:0]    end_ofs;
    logic [PAD_W-1:0]  padded;
    logic [PAD_W-1:0]  shifted;

    // zero extension so an entry near the top edge never indexes outside the vector
    assign padded = {{ENTRY_MAX_W{1'b0}}, data_i};

    always_comb begin
        diff    = entry_addr_i - base_i;
        end_ofs = {1'b0, diff[OFS_W-1:0]} + (OFS_W+1)'(entry_bytes(esize_i));
        hit_o   = (diff < ADDR_W'(WIN_BYTES)) && (end_ofs <= (OFS_W+1)'(WIN_BYTES));
        shifted = padded >> {diff[OFS_W-1:0], 3'b000};
        raw_o   = shifted[ENTRY_MAX_W-1:0];
    end
endmodule

// File: rtl/jtbl_target_form.sv
module jtbl_target_form
    import jtbl_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic [ENTRY_MAX_W-1:0] raw_i,
    input  logic [1:0]             esize_i,
    input  logic                   splice_i,
    input  logic [ADDR_W-1:0]      br_addr_i,
    output logic [ADDR_W-1:0]      target_o
);
    logic [ENTRY_MAX_W-1:0] sext;
    logic [ENTRY_MAX_W-1:0] mask;
    logic [ENTRY_MAX_W-1:0] disp;

    always_comb begin
        unique case (esize_i)
            SZ_1B: begin
                sext = {{56{raw_i[7]}}, raw_i[7:0]};
                mask = 64'h0000_0000_0000_00FF;
            end
            SZ_2B: begin
                sext = {{48{raw_i[15]}}, raw_i[15:0]};
                mask = 64'h0000_0000_0000_FFFF;
            end
            SZ_4B: begin
                sext = {{32{raw_i[31]}}, raw_i[31:0]};
                mask = 64'h0000_0000_FFFF_FFFF;
            end
            default: begin
                sext = raw_i;
                mask = '1;
            end
        endcase
        disp = sext << 2;
        if (splice_i) begin
            target_o = (br_addr_i & ~mask[ADDR_W-1:0]) | (raw_i[ADDR_W-1:0] & mask[ADDR_W-1:0]);
        end else begin
            target_o = br_addr_i + disp[ADDR_W-1:0];
        end
    end
endmodule

// File: rtl/jtbl_branch_unit.sv
module jtbl_branch_unit
    import jtbl_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int IDX_W     = 32,
    parameter int MAX_W     = 16,
    parameter int BUF_WORDS = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [IDX_W-1:0]        sel_i,
    input  logic [MAX_W-1:0]        bound_i,
    input  logic [1:0]              esize_i,
    input  logic                    splice_i,
    input  logic [ADDR_W-1:0]       br_addr_i,
    input  logic [ADDR_W-1:0]       ibuf_base_i,
    input  logic [BUF_WORDS*32-1:0] ibuf_data_i,
    output logic                    ic_req_o,
    output logic [ADDR_W-1:0]       ic_addr_o,
    input  logic                    ic_valid_i,
    input  logic [ENTRY_MAX_W-1:0]  ic_data_i,
    output logic                    ready_o,
    output logic                    done_o,
    output logic                    illegal_o,
    output logic [ADDR_W-1:0]       target_o
);
    typedef struct packed {
        fsm_e              fsm;
        logic              done;
        logic              illegal;
        logic [ADDR_W-1:0] target;
        logic [ADDR_W-1:0] eaddr;
        logic [ADDR_W-1:0] br;
        logic [1:0]        esize;
        logic              splice;
    } unit_st_t;

    unit_st_t st_d, st_q;

    logic [ADDR_W-1:0]      entry_addr;
    logic                   buf_hit;
    logic [ENTRY_MAX_W-1:0] buf_raw;
    logic                   bad_req;

    logic [ENTRY_MAX_W-1:0] fm_raw;
    logic [1:0]             fm_esize;
    logic                   fm_splice;
    logic [ADDR_W-1:0]      fm_br;
    logic [ADDR_W-1:0]      fm_target;

    jtbl_slot_calc #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .MAX_W(MAX_W)
    ) u_slot (
        .sel_i        (sel_i),
        .bound_i      (bound_i),
        .esize_i      (esize_i),
        .br_addr_i    (br_addr_i),
        .entry_addr_o (entry_addr)
    );

    jtbl_ibuf_pick #(
        .ADDR_W(ADDR_W), .BUF_WORDS(BUF_WORDS)
    ) u_pick (
        .base_i       (ibuf_base_i),
        .data_i       (ibuf_data_i),
        .entry_addr_i (entry_addr),
        .esize_i      (esize_i),
        .hit_o        (buf_hit),
        .raw_o        (buf_raw)
    );

    // one formatter shared by the buffer path (idle) and the cache path (miss wait)
    always_comb begin
        if (st_q.fsm == ST_MISS) begin
            fm_raw    = ic_data_i;
            fm_esize  = st_q.esize;
            fm_splice = st_q.splice;
            fm_br     = st_q.br;
        end else begin
            fm_raw    = buf_raw;
            fm_esize  = esize_i;
            fm_splice = splice_i;
            fm_br     = br_addr_i;
        end
    end

    jtbl_target_form #(
        .ADDR_W(ADDR_W)
    ) u_form (
        .raw_i     (fm_raw),
        .esize_i   (fm_esize),
        .splice_i  (fm_splice),
        .br_addr_i (fm_br),
        .target_o  (fm_target)
    );

    assign bad_req = splice_i && (esize_i == SZ_1B);

    always_comb begin
        st_d         = st_q;
        st_d.done    = 1'b0;
        st_d.illegal = 1'b0;
        unique case (st_q.fsm)
            ST_IDLE: begin
                if (start_i) begin
                    if (bad_req) begin
                        st_d.done    = 1'b1;
                        st_d.illegal = 1'b1;
                        st_d.target  = br_addr_i;
                    end else if (buf_hit) begin
                        st_d.done   = 1'b1;
                        st_d.target = fm_target;
                    end else begin
                        st_d.fsm    = ST_MISS;
                        st_d.eaddr  = entry_addr;
                        st_d.br     = br_addr_i;
                        st_d.esize  = esize_i;
                        st_d.splice = splice_i;
                    end
                end
            end
            default: begin
                if (ic_valid_i) begin
                    st_d.fsm    = ST_IDLE;
                    st_d.done   = 1'b1;
                    st_d.target = fm_target;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready_o   = (st_q.fsm == ST_IDLE);
    assign ic_req_o  = (st_q.fsm == ST_MISS);
    assign ic_addr_o = st_q.eaddr;
    assign done_o    = st_q.done;
    assign illegal_o = st_q.illegal;
    assign target_o  = st_q.target;

    // R6
    fast_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && start_i && buf_hit && !bad_req) |=> (done_o && !ic_req_o));

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ic_req_o && !ic_valid_i) |=> (ic_req_o && $stable(ic_addr_o)));

    // R7
    miss_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ic_req_o && ic_valid_i) |=> (done_o && !ic_req_o));

    // R9
    illegal_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (done_o && !ic_req_o && target_o == $past(br_addr_i)));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ic_req_o && !ic_valid_i) |=> !done_o);
endmodule

// File: tb/jtbl_branch_unit_test.sv
module jtbl_branch_unit_test;
    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [31:0]   sel_i = '0;
    logic [15:0]   bound_i = '0;
    logic [1:0]    esize_i = '0;
    logic          splice_i = 1'b0;
    logic [63:0]   br_addr_i = '0;
    logic [63:0]   ibuf_base_i = '0;
    logic [255:0]  ibuf_data_i = '0;
    logic          ic_req_o;
    logic [63:0]   ic_addr_o;
    logic          ic_valid_i = 1'b0;
    logic [63:0]   ic_data_i = '0;
    logic          ready_o;
    logic          done_o;
    logic          illegal_o;
    logic [63:0]   target_o;

    always #2.5 clk = ~clk;

    jtbl_branch_unit uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sel_i(sel_i),
        .bound_i(bound_i), .esize_i(esize_i), .splice_i(splice_i),
        .br_addr_i(br_addr_i), .ibuf_base_i(ibuf_base_i), .ibuf_data_i(ibuf_data_i),
        .ic_req_o(ic_req_o), .ic_addr_o(ic_addr_o), .ic_valid_i(ic_valid_i),
        .ic_data_i(ic_data_i), .ready_o(ready_o), .done_o(done_o),
        .illegal_o(illegal_o), .target_o(target_o)
    );

    typedef struct packed {
        logic [31:0] sel;
        logic [15:0] bnd;
        logic [1:0]  sz;
        logic        sp;
        logic [63:0] br;
        logic [63:0] base;
        logic        hit;
        logic        ill;
        logic [63:0] ea;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VT [NV] = '{
        '{32'd2,         16'd5,     2'd1, 1'b0, 64'h1000, 64'h1000, 1'b1, 1'b0, 64'h1008},
        '{32'd0,         16'd0,     2'd0, 1'b0, 64'h1000, 64'h1000, 1'b1, 1'b0, 64'h1004},
        '{32'd7,         16'd3,     2'd2, 1'b0, 64'h1000, 64'h1000, 1'b1, 1'b0, 64'h1014},
        '{32'hFFFFFFFF,  16'd2,     2'd3, 1'b0, 64'h1000, 64'h1000, 1'b0, 1'b0, 64'h101C},
        '{32'd3,         16'd3,     2'd1, 1'b0, 64'h1000, 64'h1000, 1'b1, 1'b0, 64'h100A},
        '{32'd4,         16'd3,     2'd1, 1'b0, 64'h1000, 64'h1000, 1'b1, 1'b0, 64'h100C},
        '{32'd100,       16'd200,   2'd2, 1'b0, 64'h1000, 64'h1000, 1'b0, 1'b0, 64'h1194},
        '{32'd65535,     16'd65535, 2'd3, 1'b0, 64'h1000, 64'h1000, 1'b0, 1'b0, 64'h80FFC},
        '{32'd70000,     16'd65535, 2'd0, 1'b0, 64'h1000, 64'h1000, 1'b0, 1'b0, 64'h11004},
        '{32'd1,         16'd4,     2'd1, 1'b1, 64'h1000, 64'h1000, 1'b1, 1'b0, 64'h1006},
        '{32'd2,         16'd4,     2'd2, 1'b1, 64'h1000, 64'h1000, 1'b1, 1'b0, 64'h100C},
        '{32'd0,         16'd0,     2'd3, 1'b1, 64'h1000, 64'h1000, 1'b1, 1'b0, 64'h1004},
        '{32'd0,         16'd0,     2'd0, 1'b1, 64'h1000, 64'h1000, 1'b0, 1'b1, 64'h0},
        '{32'd0,         16'd0,     2'd3, 1'b0, 64'h2000, 64'h1FF0, 1'b1, 1'b0, 64'h2004},
        '{32'd2,         16'd5,     2'd2, 1'b0, 64'h2000, 64'h1FF0, 1'b1, 1'b0, 64'h200C},
        '{32'd0,         16'd0,     2'd2, 1'b0, 64'h2000, 64'h2010, 1'b0, 1'b0, 64'h2004},
        '{32'h80000000,  16'd10,    2'd2, 1'b0, 64'h1000, 64'h1000, 1'b0, 1'b0, 64'h1030},
        '{32'd1,         16'd1,     2'd1, 1'b1, 64'hFEDCBA9876540000, 64'hFEDCBA9876540000, 1'b1, 1'b0, 64'hFEDCBA9876540006},
        '{32'd3,         16'd7,     2'd2, 1'b1, 64'hFEDCBA9876540000, 64'hFEDCBA9876540100, 1'b0, 1'b0, 64'hFEDCBA9876540010},
        '{32'd5,         16'd9,     2'd3, 1'b1, 64'h1000, 64'h1000, 1'b0, 1'b0, 64'h102C}
    };

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    function automatic logic [7:0] mem_byte(input logic [63:0] a);
        return (a[7:0] * 8'h9D) ^ a[15:8] ^ 8'h3C;
    endfunction

    function automatic logic [63:0] model_target(input logic [63:0] br, input logic [63:0] ea,
                                                 input logic [1:0] sz, input logic sp);
        int nb = 1 << sz;
        logic [63:0] raw = '0;
        logic [63:0] mask;
        for (int k = 0; k < nb; k++) raw[8*k +: 8] = mem_byte(ea + 64'(k));
        mask = (sz == 2'd3) ? '1 : ((64'd1 << (8 * nb)) - 64'd1);
        if (sp) return (br & ~mask) | raw;
        if (raw[8*nb-1]) raw = raw | ~mask;
        return br + (raw << 2);
    endfunction

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive_req(input vec_t v);
        sel_i = v.sel; bound_i = v.bnd; esize_i = v.sz; splice_i = v.sp;
        br_addr_i = v.br; ibuf_base_i = v.base;
        for (int b = 0; b < 32; b++) ibuf_data_i[8*b +: 8] = mem_byte(v.base + 64'(b));
        start_i = 1'b1;
    endtask

    task automatic answer_cache();
        for (int k = 0; k < 8; k++) ic_data_i[8*k +: 8] = mem_byte(ic_addr_o + 64'(k));
        ic_valid_i = 1'b1;
    endtask

    task automatic run_vec(input int i);
        vec_t v = VT[i];
        logic [63:0] exp_t = model_target(v.br, v.ea, v.sz, v.sp);
        string addr_tag = (v.sel[31] || v.sel > {16'd0, v.bnd}) ? "R3 R4" : "R2 R4";
        string tgt_tag  = v.sp ? "R8" : "R5";
        @(negedge clk);
        drive_req(v);
        @(negedge clk);
        start_i = 1'b0;
        if (v.ill) begin
            chk(done_o && illegal_o && !ic_req_o, "R9 flags", {61'd0, done_o, illegal_o, ic_req_o}, 64'h6);
            chk(target_o == v.br, "R9 target", target_o, v.br);
        end else if (v.hit) begin
            chk(done_o && !ic_req_o && !illegal_o, "R6 buffer path", {62'd0, done_o, ic_req_o}, 64'h2);
            chk(target_o == exp_t, tgt_tag, target_o, exp_t);
        end else begin
            chk(ic_req_o && !done_o, "R7 miss request", {62'd0, ic_req_o, done_o}, 64'h2);
            chk(ic_addr_o == v.ea, addr_tag, ic_addr_o, v.ea);
            repeat (i % 4) @(negedge clk);
            chk(ic_req_o && ic_addr_o == v.ea, "R7 hold", ic_addr_o, v.ea);
            answer_cache();
            @(negedge clk);
            ic_valid_i = 1'b0;
            chk(done_o && !ic_req_o, "R7 completion", {62'd0, done_o, ic_req_o}, 64'h2);
            chk(target_o == exp_t, tgt_tag, target_o, exp_t);
        end
        @(negedge clk);
        chk(!done_o && ready_o, "R11 single pulse", {62'd0, done_o, ready_o}, 64'h1);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<20000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ready_o && !done_o && !illegal_o && !ic_req_o, "R1 in reset",
            {60'd0, ready_o, done_o, illegal_o, ic_req_o}, 64'h8);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready_o && !done_o && !ic_req_o, "R1 after reset",
            {61'd0, ready_o, done_o, ic_req_o}, 64'h4);

        for (int i = 0; i < NV; i++) run_vec(i);

        // R10: stray strobe during a pending cache read
        begin
            logic [63:0] exp_t = model_target(VT[6].br, VT[6].ea, VT[6].sz, VT[6].sp);
            @(negedge clk);
            drive_req(VT[6]);
            @(negedge clk);
            drive_req(VT[0]);
            @(negedge clk);
            start_i = 1'b0;
            chk(ic_req_o && ic_addr_o == VT[6].ea && !done_o, "R10 address kept", ic_addr_o, VT[6].ea);
            @(negedge clk);
            answer_cache();
            @(negedge clk);
            ic_valid_i = 1'b0;
            chk(done_o && target_o == exp_t, "R10 target kept", target_o, exp_t);
            @(negedge clk);
            chk(!done_o && !ic_req_o && ready_o, "R10 no second completion",
                {61'd0, done_o, ic_req_o, ready_o}, 64'h1);
        end

        // R1: reset while a cache read is pending
        @(negedge clk);
        drive_req(VT[15]);
        @(negedge clk);
        start_i = 1'b0;
        chk(ic_req_o, "R7 pending before reset", {63'd0, ic_req_o}, 64'h1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(ready_o && !ic_req_o && !done_o, "R1 mid-operation reset",
            {61'd0, ready_o, ic_req_o, done_o}, 64'h4);
        rst_n = 1'b1;
        @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule